// File: doc/BRIEF.md
# Passive LCD Panel Timing Generator

This block turns a stream of packed pixel words into the control and data waveforms that a passive matrix LCD panel expects. It produces a shift clock that moves each bus word into the panel's column shift register, a line load pulse that commits a finished row to the row drivers, a frame start pulse that sends the panel's row pointer back to the top, and an AC-bias output that flips every few frames so the liquid crystal never sees a lasting DC voltage. Every control output has its own polarity bit. The data bus is either 4 or 8 bits wide.

In single-scan mode each bus word carries pixels of one row. In dual-scan mode the panel is split into an upper and a lower half that are refreshed together. The low half of the bus carries pixels of an upper-half row and the high half carries pixels of the matching lower-half row, so each frame needs only half as many lines. The upstream source packs the words in that layout. The block passes each accepted word through unchanged, except that it forces the unused upper nibble to zero in 4-bit mode. Pixels arrive on a ready/valid port. When no word is offered in time, the block holds the shift clock instead of sending stale data, and it records the event in a sticky underrun flag. All configuration inputs are sampled once per frame, at the frame boundary.

Top module: `lcd_scan_timer`

## Requirements
- R1: The shift clock asserts `max(1, width >> k)` times per line, where `k` is set by `cfg_bus8` and `cfg_dual`: k=2 for (0,0), k=3 for (1,0), k=1 for (0,1) and k=2 for (1,1). These are 4, 8, 2 and 4 pixels per clock per row.
- R2: Each shift clock assertion presents the next accepted pixel word on `lcd_data`. The word is on the bus from at least one cycle before the asserted level and stays unchanged while the shift clock is asserted. With `cfg_bus8`=0, `lcd_data[7:4]` is 0. In dual-scan mode bits [3:0] (8-bit) or [1:0] (4-bit) feed the upper half, and the other half of the active bus feeds the lower half.
- R3: Each line ends with a line load pulse that lasts LOAD_LEN cycles. The shift clock is deasserted during it. A frame has `max(1, height)` lines in single-scan mode and `max(1, height >> 1)` lines in dual-scan mode.
- R4: The frame start output is asserted exactly during the line load pulse of the first line of every frame, and at no other time.
- R5: The AC-bias output flips at the end of every N-th frame, where N is `cfg_ac_every`. A value of 0 acts as 1.
- R6: Each control output equals its active-high level XOR its polarity bit: `cfg_pol[0]` shift clock, `[1]` line load, `[2]` frame start, `[3]` AC bias. The idle levels equal the polarity bits.
- R7: While `pix_valid` is low, no new shift clock assertion is issued. `underrun` goes to 1 when a word is due and missing, stays 1, and is cleared only by reset.
- R8: A change on any configuration input takes effect only from the first line of the next frame. The frame in progress keeps its line length, line count, polarities and AC rate.
- R9: During reset all panel outputs, `lcd_data`, `pix_ready` and `underrun` are 0, whatever the configuration inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | WID_W | Panel width in pixels |
| cfg_height | input | HGT_W | Panel height in rows |
| cfg_bus8 | input | 1 | 1: 8-bit data bus, 0: 4-bit |
| cfg_dual | input | 1 | 1: dual-scan, 0: single-scan |
| cfg_pol | input | 4 | Polarity bits (shift, load, frame, AC) |
| cfg_ac_every | input | AC_W | Frames between AC-bias flips |
| pix_valid | input | 1 | Pixel word offered |
| pix_ready | output | 1 | Pixel word taken on this cycle if valid |
| pix_data | input | 8 | Packed pixel word |
| lcd_shift | output | 1 | Panel shift clock |
| lcd_load | output | 1 | Line load pulse |
| lcd_frame | output | 1 | Frame start pulse |
| lcd_ac | output | 1 | AC-bias output |
| lcd_data | output | 8 | Panel data bus |
| underrun | output | 1 | Sticky missing-pixel flag |

## Verification
The bench aims at the configurations where the shift count rounds down to zero or the line count collapses to one. If the 1-clamp is missing, the design either hangs or lets its counters wrap. A one-line frame must raise the frame start on every load, so an off-by-one in the row counter shows up at once. The bench drops `pix_valid` in the middle of a line. A design that shifts anyway puts words on the panel that no handshake delivered, and one without a sticky flag loses the underrun once data comes back. It also changes the width and height in the middle of a frame. A design that applies them at once cuts the current frame's lines short or places the frame start on the wrong line.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  localparam int BUS_W = 8;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_WAIT,
    ST_SETUP,
    ST_HIGH,
    ST_LOAD
  } scan_state_e;

  // log2 of pixels per shift clock for one panel row
  function automatic int unsigned px_shift(logic bus8, logic dual);
    if (dual) return bus8 ? 2 : 1;
    return bus8 ? 3 : 2;
  endfunction

  function automatic int unsigned shifts_per_line(int unsigned width_px, logic bus8, logic dual);
    int unsigned n;
    n = width_px >> px_shift(bus8, dual);
    return (n == 0) ? 1 : n;
  endfunction

  function automatic int unsigned lines_per_frame(int unsigned rows, logic dual);
    int unsigned n;
    n = dual ? (rows >> 1) : rows;
    return (n == 0) ? 1 : n;
  endfunction

  function automatic int unsigned ac_last_count(int unsigned every);
    return (every == 0) ? 0 : every - 1;
  endfunction

  function automatic logic [BUS_W-1:0] bus_mask(logic bus8);
    logic [BUS_W-1:0] m;
    m = '1;
    if (!bus8) m[BUS_W-1:BUS_W/2] = '0;
    return m;
  endfunction

endpackage

// File: rtl/lcd_line_engine.sv
module lcd_line_engine
  import lcd_scan_pkg::*;
#(
  parameter int COL_W    = 12,
  parameter int LOAD_LEN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [COL_W-1:0] cols_lim,
  input  logic             bus8,
  input  logic             last_row,
  input  logic             pix_valid,
  input  logic [BUS_W-1:0] pix_data,
  output logic             pix_ready,
  output logic             shift_raw,
  output logic             load_raw,
  output logic             line_done,
  output logic             take_cfg,
  output logic             stall_evt,
  output logic [BUS_W-1:0] data_q
);

  localparam int LC_W = (LOAD_LEN > 1) ? $clog2(LOAD_LEN) : 1;

  scan_state_e      state;
  logic [COL_W-1:0] col;
  logic [LC_W-1:0]  ld_cnt;

  assign pix_ready = (state == ST_WAIT);
  assign stall_evt = pix_ready && !pix_valid;
  assign shift_raw = (state == ST_HIGH);
  assign load_raw  = (state == ST_LOAD);
  assign line_done = load_raw && (ld_cnt == LC_W'(LOAD_LEN - 1));
  assign take_cfg  = (state == ST_INIT) || (line_done && last_row);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_INIT;
      col    <= '0;
      ld_cnt <= '0;
      data_q <= '0;
    end else begin
      case (state)
        ST_INIT:  state <= ST_WAIT;
        ST_WAIT: begin
          if (pix_valid) begin
            data_q <= pix_data & bus_mask(bus8);
            state  <= ST_SETUP;
          end
        end
        ST_SETUP: state <= ST_HIGH;
        ST_HIGH: begin
          if (col == cols_lim - COL_W'(1)) begin
            col    <= '0;
            ld_cnt <= '0;
            state  <= ST_LOAD;
          end else begin
            col   <= col + COL_W'(1);
            state <= ST_WAIT;
          end
        end
        ST_LOAD: begin
          if (line_done) begin
            ld_cnt <= '0;
            state  <= ST_WAIT;
          end else begin
            ld_cnt <= ld_cnt + LC_W'(1);
          end
        end
        default: state <= ST_INIT;
      endcase
    end
  end

  assert_col_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    col < cols_lim);

  assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HIGH) |-> $stable(data_q));

  assert_stall_no_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && !pix_valid) |=> (state == ST_WAIT));

endmodule

// File: rtl/lcd_frame_tracker.sv
module lcd_frame_tracker
  import lcd_scan_pkg::*;
#(
  parameter int ROW_W = 10,
  parameter int AC_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] rows_lim,
  input  logic [AC_W-1:0]  ac_every,
  input  logic             line_done,
  output logic             first_row,
  output logic             last_row,
  output logic             frame_end,
  output logic             ac_raw
);

  logic [ROW_W-1:0] row;
  logic [AC_W-1:0]  ac_cnt;
  logic [AC_W-1:0]  ac_lim;

  assign ac_lim    = AC_W'(ac_last_count(32'(ac_every)));
  assign first_row = (row == '0);
  assign last_row  = (row == rows_lim - ROW_W'(1));
  assign frame_end = line_done && last_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row    <= '0;
      ac_cnt <= '0;
      ac_raw <= 1'b0;
    end else begin
      if (line_done) row <= last_row ? '0 : row + ROW_W'(1);
      if (frame_end) begin
        if (ac_cnt >= ac_lim) begin
          ac_raw <= ~ac_raw;
          ac_cnt <= '0;
        end else begin
          ac_cnt <= ac_cnt + AC_W'(1);
        end
      end
    end
  end

  assert_row_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    row < rows_lim);

  assert_ac_at_frame_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ac_raw) |-> $past(frame_end));

endmodule

// File: rtl/lcd_out_stage.sv
module lcd_out_stage
  import lcd_scan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       pol,
  input  logic             shift_in,
  input  logic             load_in,
  input  logic             frame_in,
  input  logic             ac_in,
  input  logic [BUS_W-1:0] data_in,
  output logic             shift_o,
  output logic             load_o,
  output logic             frame_o,
  output logic             ac_o,
  output logic [BUS_W-1:0] data_o
);

  logic [3:0] lvl_q;
  logic [3:0] pol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      pol_q  <= '0;
      data_o <= '0;
    end else begin
      lvl_q  <= {ac_in, frame_in, load_in, shift_in};
      pol_q  <= pol;
      data_o <= data_in;
    end
  end

  assign shift_o = lvl_q[0] ^ pol_q[0];
  assign load_o  = lvl_q[1] ^ pol_q[1];
  assign frame_o = lvl_q[2] ^ pol_q[2];
  assign ac_o    = lvl_q[3] ^ pol_q[3];

  assert_shift_quiet_in_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(lvl_q[0] && lvl_q[1]));

  assert_frame_inside_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q[2] |-> lvl_q[1]);

endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
  import lcd_scan_pkg::*;
#(
  parameter int WID_W    = 12,
  parameter int HGT_W    = 10,
  parameter int AC_W     = 8,
  parameter int LOAD_LEN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WID_W-1:0] cfg_width,
  input  logic [HGT_W-1:0] cfg_height,
  input  logic             cfg_bus8,
  input  logic             cfg_dual,
  input  logic [3:0]       cfg_pol,
  input  logic [AC_W-1:0]  cfg_ac_every,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic [7:0]       pix_data,
  output logic             lcd_shift,
  output logic             lcd_load,
  output logic             lcd_frame,
  output logic             lcd_ac,
  output logic [7:0]       lcd_data,
  output logic             underrun
);

  // configuration shadow, refreshed only at frame boundaries
  logic [WID_W-1:0] w_q;
  logic [HGT_W-1:0] h_q;
  logic             bus8_q, dual_q;
  logic [3:0]       pol_q;
  logic [AC_W-1:0]  ac_q;

  logic [WID_W-1:0] cols_lim;
  logic [HGT_W-1:0] rows_lim;
  logic             take_cfg, line_done, stall_evt;
  logic             shift_raw, load_raw, frame_raw, ac_raw;
  logic             first_row, last_row, frame_end;
  logic [BUS_W-1:0] data_q;

  assign cols_lim  = WID_W'(shifts_per_line(32'(w_q), bus8_q, dual_q));
  assign rows_lim  = HGT_W'(lines_per_frame(32'(h_q), dual_q));
  assign frame_raw = load_raw && first_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q      <= '0;
      h_q      <= '0;
      bus8_q   <= 1'b0;
      dual_q   <= 1'b0;
      pol_q    <= '0;
      ac_q     <= '0;
      underrun <= 1'b0;
    end else begin
      if (take_cfg) begin
        w_q    <= cfg_width;
        h_q    <= cfg_height;
        bus8_q <= cfg_bus8;
        dual_q <= cfg_dual;
        pol_q  <= cfg_pol;
        ac_q   <= cfg_ac_every;
      end
      if (stall_evt) underrun <= 1'b1;
    end
  end

  lcd_line_engine #(.COL_W(WID_W), .LOAD_LEN(LOAD_LEN)) u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .cols_lim  (cols_lim),
    .bus8      (bus8_q),
    .last_row  (last_row),
    .pix_valid (pix_valid),
    .pix_data  (pix_data),
    .pix_ready (pix_ready),
    .shift_raw (shift_raw),
    .load_raw  (load_raw),
    .line_done (line_done),
    .take_cfg  (take_cfg),
    .stall_evt (stall_evt),
    .data_q    (data_q)
  );

  lcd_frame_tracker #(.ROW_W(HGT_W), .AC_W(AC_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .rows_lim  (rows_lim),
    .ac_every  (ac_q),
    .line_done (line_done),
    .first_row (first_row),
    .last_row  (last_row),
    .frame_end (frame_end),
    .ac_raw    (ac_raw)
  );

  lcd_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .pol      (pol_q),
    .shift_in (shift_raw),
    .load_in  (load_raw),
    .frame_in (frame_raw),
    .ac_in    (ac_raw),
    .data_in  (data_q),
    .shift_o  (lcd_shift),
    .load_o   (lcd_load),
    .frame_o  (lcd_frame),
    .ac_o     (lcd_ac),
    .data_o   (lcd_data)
  );

  assert_underrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);

  assert_cfg_frame_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(take_cfg) |-> ($stable(w_q) && $stable(h_q) && $stable(pol_q) &&
                          $stable(bus8_q) && $stable(dual_q) && $stable(ac_q)));

  assert_take_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (line_done && !frame_end) |-> !take_cfg);

endmodule

// File: tb/test_lcd_scan_timer.sv
module test_lcd_scan_timer;

  localparam int CLK_PERIOD = 10;
  localparam int LOAD_CYC   = 2;
  localparam int NV         = 6;

  typedef struct packed {
    logic [11:0] w;
    logic [9:0]  h;
    logic        b8;
    logic        du;
    logic [3:0]  pol;
    logic [7:0]  acn;
    logic [7:0]  frames;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{12'd16, 10'd4, 1'b0, 1'b0, 4'h0, 8'd2, 8'd4},
    '{12'd16, 10'd4, 1'b1, 1'b0, 4'hF, 8'd1, 8'd3},
    '{12'd16, 10'd6, 1'b0, 1'b1, 4'h5, 8'd3, 8'd6},
    '{12'd24, 10'd4, 1'b1, 1'b1, 4'hA, 8'd0, 8'd3},
    '{12'd2,  10'd1, 1'b1, 1'b0, 4'h3, 8'd2, 8'd4},
    '{12'd8,  10'd3, 1'b0, 1'b1, 4'hC, 8'd1, 8'd3}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cfg_width = 12'd16;
  logic [9:0]  cfg_height = 10'd4;
  logic        cfg_bus8 = 1'b0;
  logic        cfg_dual = 1'b0;
  logic [3:0]  cfg_pol = 4'h0;
  logic [7:0]  cfg_ac_every = 8'd1;
  logic        pix_valid = 1'b1;
  logic        pix_ready;
  logic [7:0]  pix_data;
  logic        lcd_shift, lcd_load, lcd_frame, lcd_ac, underrun;
  logic [7:0]  lcd_data;

  int checks = 0;
  int failures = 0;
  bit wd_fired = 1'b0;

  // bench-side model state
  logic [7:0] seed = 8'h21;
  logic [7:0] sent [0:1023];
  int  wr_i = 0, rd_i = 0;
  bit  mon_en = 1'b0;
  int  exp_cols, exp_rows, pend_cols, pend_rows, exp_acn;
  logic [3:0] exp_pol;
  bit  exp_b8, exp_ac;
  int  shifts, tot_shifts, line_idx, frames_done, ac_since, ld_len;
  bit  sh, ld, fr, ac, sh_p, ld_p;
  logic [7:0] data_p;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_scan_timer #(.WID_W(12), .HGT_W(10), .AC_W(8), .LOAD_LEN(LOAD_CYC)) i_lcd_scan_timer (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_bus8(cfg_bus8), .cfg_dual(cfg_dual), .cfg_pol(cfg_pol), .cfg_ac_every(cfg_ac_every),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .lcd_shift(lcd_shift), .lcd_load(lcd_load), .lcd_frame(lcd_frame), .lcd_ac(lcd_ac),
    .lcd_data(lcd_data), .underrun(underrun)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  function automatic int cols_of(int w, bit b8, bit du);
    int ppc;
    ppc = b8 ? 8 : 4;
    if (du) ppc = ppc / 2;
    return (w / ppc == 0) ? 1 : w / ppc;
  endfunction

  function automatic int rows_of(int h, bit du);
    int r;
    r = du ? h / 2 : h;
    return (r == 0) ? 1 : r;
  endfunction

  // pixel source: a new word after each accepted handshake
  always @(posedge clk) begin
    if (!rst_n) begin
      pix_data <= seed;
      wr_i = 0;
    end else if (pix_valid && pix_ready) begin
      sent[wr_i % 1024] = pix_data & (exp_b8 ? 8'hFF : 8'h0F);
      wr_i++;
      pix_data <= pix_data + 8'h3B;
    end
  end

  // panel-side monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (mon_en) begin
      sh = lcd_shift ^ exp_pol[0];
      ld = lcd_load  ^ exp_pol[1];
      fr = lcd_frame ^ exp_pol[2];
      ac = lcd_ac    ^ exp_pol[3];
      if (sh && ld) chk(1'b0, "R3", "shift asserted during load", 1, 0);
      if (sh && !sh_p) begin
        shifts++;
        tot_shifts++;
        chk(lcd_data == sent[rd_i % 1024], "R2", "word at shift edge", int'(lcd_data), int'(sent[rd_i % 1024]));
        chk(lcd_data == data_p, "R2", "word set up before shift", int'(lcd_data), int'(data_p));
        rd_i++;
      end
      if (ld) ld_len++;
      if (ld && !ld_p) begin
        chk(shifts == exp_cols, "R1", "shifts per line", shifts, exp_cols);
        shifts = 0;
        chk(fr == (line_idx == 0), "R4", "frame start vs line index", int'(fr), int'(line_idx == 0));
        line_idx++;
      end else if (fr && !ld) begin
        chk(1'b0, "R4", "frame start outside load", 1, 0);
      end
      if (!ld && ld_p) begin
        chk(ld_len == LOAD_CYC, "R3", "load pulse length", ld_len, LOAD_CYC);
        ld_len = 0;
        if (line_idx == exp_rows) begin
          frames_done++;
          line_idx = 0;
          ac_since++;
          if (ac_since >= ((exp_acn == 0) ? 1 : exp_acn)) begin
            exp_ac = ~exp_ac;
            ac_since = 0;
          end
          chk(ac == exp_ac, "R5", "AC bias after frame", int'(ac), int'(exp_ac));
          exp_cols = pend_cols;
          exp_rows = pend_rows;
        end
      end
      sh_p = sh;
      ld_p = ld;
      data_p = lcd_data;
    end
  end

  task automatic setup_vec(input vec_t v, input int idx);
    mon_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    cfg_width = v.w; cfg_height = v.h; cfg_bus8 = v.b8; cfg_dual = v.du;
    cfg_pol = v.pol; cfg_ac_every = v.acn;
    seed = 8'(8'h21 + 8'(idx) * 8'h17);
    exp_cols = cols_of(int'(v.w), v.b8, v.du);
    exp_rows = rows_of(int'(v.h), v.du);
    pend_cols = exp_cols; pend_rows = exp_rows;
    exp_pol = v.pol; exp_acn = int'(v.acn); exp_b8 = v.b8; exp_ac = 1'b0;
    shifts = 0; tot_shifts = 0; line_idx = 0; frames_done = 0; ac_since = 0; ld_len = 0;
    rd_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1;
    // idle levels follow the polarity bits
    chk({lcd_ac, lcd_frame, lcd_load, lcd_shift} == v.pol, "R6", "idle levels",
        int'({lcd_ac, lcd_frame, lcd_load, lcd_shift}), int'(v.pol));
    sh_p = lcd_shift ^ exp_pol[0];
    ld_p = lcd_load ^ exp_pol[1];
    data_p = lcd_data;
    mon_en = 1'b1;
  endtask

  task automatic wait_frames(input int n);
    while (frames_done < n && !wd_fired) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    wd_fired = 1'b1;
  end

  initial begin
    int s0;
    // R9: reset state, with every polarity bit set on the inputs
    cfg_pol = 4'hF;
    pix_valid = 1'b1;
    repeat (4) @(negedge clk);
    chk({lcd_ac, lcd_frame, lcd_load, lcd_shift} == 4'h0, "R9", "outputs in reset",
        int'({lcd_ac, lcd_frame, lcd_load, lcd_shift}), 0);
    chk(lcd_data == 8'h00, "R9", "data in reset", int'(lcd_data), 0);
    chk(!pix_ready && !underrun, "R9", "ready/underrun in reset", int'({pix_ready, underrun}), 0);

    // table walk: R1..R6 through the monitor
    for (int i = 0; i < NV; i++) begin
      setup_vec(VECS[i], i);
      wait_frames(int'(VECS[i].frames));
      chk(frames_done >= int'(VECS[i].frames), "R3", "frames completed", frames_done, int'(VECS[i].frames));
      chk(underrun == 1'b0, "R7", "no underrun with steady data", int'(underrun), 0);
    end

    // R7: missing pixels stall the shift clock and latch the flag
    setup_vec(VECS[0], 7);
    wait_frames(1);
    repeat (5) @(negedge clk);
    pix_valid = 1'b0;
    repeat (10) @(negedge clk);
    s0 = tot_shifts;
    repeat (20) @(negedge clk);
    chk(tot_shifts == s0, "R7", "shift clock held while starved", tot_shifts, s0);
    chk(underrun == 1'b1, "R7", "underrun raised", int'(underrun), 1);
    pix_valid = 1'b1;
    wait_frames(3);
    chk(underrun == 1'b1, "R7", "underrun sticky", int'(underrun), 1);
    mon_en = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(underrun == 1'b0, "R7", "reset clears underrun", int'(underrun), 0);

    // R8: mid-frame geometry change waits for the frame boundary
    setup_vec(VECS[0], 8);
    while (!(frames_done >= 1 && line_idx >= 2) && !wd_fired) @(negedge clk);
    cfg_width = 12'd32;
    cfg_height = 10'd2;
    pend_cols = cols_of(32, 1'b0, 1'b0);
    pend_rows = rows_of(2, 1'b0);
    wait_frames(4);
    chk(exp_cols == 8 && exp_rows == 2, "R8", "new geometry adopted", exp_cols, 8);
    chk(underrun == 1'b0, "R8", "no underrun across change", int'(underrun), 0);
    mon_en = 1'b0;

    if (wd_fired) chk(1'b0, "R1", "watchdog expired", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule